// File: doc/BRIEF.md
# Priority and Lifetime Frame Scheduler

The scheduler keeps a queue of frame pointers for a wireless access point and hands out the most urgent one on request. Storage is split into one table per priority level, and every entry carries a remaining-lifetime count. A periodic timebase tick starts a background pass that counts each lifetime down. An entry whose lifetime reaches zero climbs to the next more urgent table. Software reaches the tables only after it holds a semaphore granted by the block, and the hardware leaves the tables alone while that grant stands.

All table work is done by one controller that walks the RAM one slot per cycle. The controller does three kinds of scan. Ageing scans tables from most to least urgent. Election scans all tables and keeps the best candidate so far. Insertion scans only the target table for its first free slot. New frames enter through a valid/ready insert channel. Elect requests use a valid/ready channel, and the elected pointer returns on a response channel held until accepted.

Top module: `frame_sched`

## Requirements
- R1: After reset all tables are empty, `sem_grant` and `rsp_valid` are low, and both `ins_ready` and `el_ready` are high.
- R2: An accepted insert writes the lowest-numbered free slot of the table selected by `ins_prio` (0 least urgent, 3 most urgent). It then pulses `ins_done` for one cycle with `ins_err` low.
- R3: An insert into a table with no free slot pulses `ins_done` with `ins_err` high and leaves every table unchanged.
- R4: An elect returns the valid entry with the highest priority. Among those it picks the lowest remaining lifetime, and among those the lowest slot index. The response has `rsp_found` high and carries that entry's pointer and priority, and the entry is removed.
- R5: An elect while every table is empty yields a response with `rsp_found` low.
- R6: A response stays valid with stable contents until `rsp_ready` is high on a clock edge. No further elect is accepted while a response is pending.
- R7: Each tick ages every valid entry exactly once: a non-zero lifetime drops by one and a zero lifetime stays zero.
- R8: An entry of a non-top table whose aged lifetime is zero moves to the same slot of the next more urgent table, with its lifetime reloaded to `LIFE_RELOAD`, if that slot is free. Otherwise it stays in place with lifetime zero and tries again on the next tick.
- R9: An expiring entry of the most urgent table stays there with its lifetime held at zero.
- R10: `sem_grant` rises only while no scan runs. While it is high no scan starts, `ins_ready` and `el_ready` are low, and no `ins_done` or response appears.
- R11: A tick that arrives during a scan or while the semaphore is held is kept, and its ageing pass runs before any pending elect or insert once the block is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase pulse requesting one ageing pass |
| sem_req | input | 1 | Software asks for exclusive table access |
| sem_grant | output | 1 | Exclusive access granted to software |
| ins_valid | input | 1 | Insert request valid |
| ins_ready | output | 1 | Insert request accepted on this edge if valid |
| ins_ptr | input | PTR_W | Frame pointer to queue |
| ins_prio | input | log2(NUM_PRIO) | Target priority table |
| ins_life | input | LIFE_W | Initial lifetime |
| ins_done | output | 1 | One-cycle pulse: insert finished |
| ins_err | output | 1 | Qualified by ins_done: table was full |
| el_valid | input | 1 | Elect request valid |
| el_ready | output | 1 | Elect request accepted on this edge if valid |
| rsp_valid | output | 1 | Election result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_found | output | 1 | A frame was elected |
| rsp_ptr | output | PTR_W | Elected frame pointer |
| rsp_prio | output | log2(NUM_PRIO) | Table the elected frame came from |

## Verification
Several properties are checked on every cycle: the grant only appears while the controller is idle, a pending response holds still under back-pressure, a tick is always latched, a done pulse only follows an insert scan, and the promotion port never writes the least urgent table. Other behaviours can only be shown by the bench's scenarios against its reference tables. These are which entry wins an election, what ageing and promotion do to later elections, that a full-table insert leaves no trace, and that a deferred tick ages the tables before a pending elect.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_AGE,
    S_ELECT,
    S_ELDONE,
    S_INS
  } fs_state_t;
endpackage

// File: rtl/fs_table.sv
module fs_table #(
  parameter int NUM_PRIO = 4,
  parameter int SLOTS    = 64,
  parameter int PTR_W    = 32,
  parameter int LIFE_W   = 16,
  localparam int BW = $clog2(NUM_PRIO),
  localparam int SW = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BW-1:0]     rd_bank,
  input  logic [SW-1:0]     rd_slot,
  output logic              a_vld,
  output logic [PTR_W-1:0]  a_ptr,
  output logic [LIFE_W-1:0] a_life,
  output logic              n_vld,
  input  logic              wa_en,
  input  logic [BW-1:0]     wa_bank,
  input  logic [SW-1:0]     wa_slot,
  input  logic              wa_vld,
  input  logic [PTR_W-1:0]  wa_ptr,
  input  logic [LIFE_W-1:0] wa_life,
  input  logic              wb_en,
  input  logic [BW-1:0]     wb_bank,
  input  logic [PTR_W-1:0]  wb_ptr,
  input  logic [LIFE_W-1:0] wb_life
);
  localparam logic [BW-1:0] TOPB = BW'(NUM_PRIO - 1);

  logic              vld_q  [NUM_PRIO][SLOTS];
  logic [PTR_W-1:0]  ptr_q  [NUM_PRIO][SLOTS];
  logic [LIFE_W-1:0] life_q [NUM_PRIO][SLOTS];

  assign a_vld  = vld_q[rd_bank][rd_slot];
  assign a_ptr  = ptr_q[rd_bank][rd_slot];
  assign a_life = life_q[rd_bank][rd_slot];
  assign n_vld  = (rd_bank == TOPB) ? 1'b1 : vld_q[rd_bank + BW'(1)][rd_slot];

  // Port B promotes into the same slot as the read address, one bank up.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_PRIO; b++)
        for (int s = 0; s < SLOTS; s++) begin
          vld_q[b][s]  <= 1'b0;
          ptr_q[b][s]  <= '0;
          life_q[b][s] <= '0;
        end
    end else begin
      if (wa_en) begin
        vld_q[wa_bank][wa_slot]  <= wa_vld;
        ptr_q[wa_bank][wa_slot]  <= wa_ptr;
        life_q[wa_bank][wa_slot] <= wa_life;
      end
      if (wb_en) begin
        vld_q[wb_bank][rd_slot]  <= 1'b1;
        ptr_q[wb_bank][rd_slot]  <= wb_ptr;
        life_q[wb_bank][rd_slot] <= wb_life;
      end
    end
  end

  // R8
  promo_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_bank != '0 && !(wa_en && wa_bank == wb_bank && wa_slot == rd_slot)));
endmodule

// File: rtl/fs_ctrl.sv
module fs_ctrl
  import fs_pkg::*;
#(
  parameter int NUM_PRIO    = 4,
  parameter int SLOTS       = 64,
  parameter int PTR_W       = 32,
  parameter int LIFE_W      = 16,
  parameter int LIFE_RELOAD = 8,
  localparam int BW = $clog2(NUM_PRIO),
  localparam int SW = $clog2(SLOTS),
  localparam int CW = BW + SW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              sem_req,
  output logic              sem_grant,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [PTR_W-1:0]  ins_ptr,
  input  logic [BW-1:0]     ins_prio,
  input  logic [LIFE_W-1:0] ins_life,
  output logic              ins_done,
  output logic              ins_err,
  input  logic              el_valid,
  output logic              el_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_found,
  output logic [PTR_W-1:0]  rsp_ptr,
  output logic [BW-1:0]     rsp_prio,
  output logic [BW-1:0]     rd_bank,
  output logic [SW-1:0]     rd_slot,
  input  logic              a_vld,
  input  logic [PTR_W-1:0]  a_ptr,
  input  logic [LIFE_W-1:0] a_life,
  input  logic              n_vld,
  output logic              wa_en,
  output logic [BW-1:0]     wa_bank,
  output logic [SW-1:0]     wa_slot,
  output logic              wa_vld,
  output logic [PTR_W-1:0]  wa_ptr,
  output logic [LIFE_W-1:0] wa_life,
  output logic              wb_en,
  output logic [BW-1:0]     wb_bank,
  output logic [PTR_W-1:0]  wb_ptr,
  output logic [LIFE_W-1:0] wb_life
);
  localparam logic [BW-1:0] TOPB = BW'(NUM_PRIO - 1);
  localparam logic [CW-1:0] LASTC = CW'(NUM_PRIO * SLOTS - 1);

  fs_state_t         state;
  logic [CW-1:0]     cnt;
  logic              tick_pend, age_go;
  logic [PTR_W-1:0]  cap_ptr;
  logic [BW-1:0]     cap_prio;
  logic [LIFE_W-1:0] cap_life;
  logic              bst_have;
  logic [BW-1:0]     bst_bank;
  logic [SW-1:0]     bst_slot;
  logic [PTR_W-1:0]  bst_ptr;
  logic [LIFE_W-1:0] bst_life;
  logic [LIFE_W-1:0] aged;
  logic              free_idle, better;

  assign free_idle = (state == S_IDLE) && !sem_req && !sem_grant;
  assign el_ready  = free_idle && !tick_pend && !rsp_valid;
  assign ins_ready = free_idle && !tick_pend && !el_valid;
  assign age_go    = free_idle && tick_pend;

  assign rd_bank = (state == S_INS) ? cap_prio : TOPB - cnt[CW-1:SW];
  assign rd_slot = cnt[SW-1:0];
  assign aged    = (a_life == '0) ? '0 : a_life - LIFE_W'(1);
  assign better  = a_vld && (!bst_have || rd_bank > bst_bank ||
                             (rd_bank == bst_bank && a_life < bst_life));

  always_comb begin
    wa_en = 1'b0; wa_bank = rd_bank; wa_slot = rd_slot; wa_vld = 1'b1;
    wa_ptr = a_ptr; wa_life = aged;
    wb_en = 1'b0; wb_bank = rd_bank + BW'(1); wb_ptr = a_ptr;
    wb_life = LIFE_W'(LIFE_RELOAD);
    unique case (state)
      S_AGE: if (a_vld) begin
        wa_en = 1'b1;
        if (aged == '0 && rd_bank != TOPB && !n_vld) begin
          wb_en  = 1'b1;
          wa_vld = 1'b0;
        end
      end
      S_INS: if (!a_vld) begin
        wa_en = 1'b1; wa_ptr = cap_ptr; wa_life = cap_life;
      end
      S_ELDONE: if (bst_have) begin
        wa_en = 1'b1; wa_bank = bst_bank; wa_slot = bst_slot; wa_vld = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; tick_pend <= 1'b0; sem_grant <= 1'b0;
      cap_ptr <= '0; cap_prio <= '0; cap_life <= '0;
      bst_have <= 1'b0; bst_bank <= '0; bst_slot <= '0; bst_ptr <= '0; bst_life <= '0;
      rsp_valid <= 1'b0; rsp_found <= 1'b0; rsp_ptr <= '0; rsp_prio <= '0;
      ins_done <= 1'b0; ins_err <= 1'b0;
    end else begin
      ins_done  <= 1'b0;
      tick_pend <= tick | (tick_pend & ~age_go);
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          sem_grant <= sem_req;
          cnt <= '0;
          if (age_go) state <= S_AGE;
          else if (el_valid && el_ready) begin
            state <= S_ELECT; bst_have <= 1'b0;
          end else if (ins_valid && ins_ready) begin
            state <= S_INS;
            cap_ptr <= ins_ptr; cap_prio <= ins_prio; cap_life <= ins_life;
          end
        end
        S_AGE: begin
          cnt <= cnt + CW'(1);
          if (cnt == LASTC) state <= S_IDLE;
        end
        S_ELECT: begin
          if (better) begin
            bst_have <= 1'b1; bst_bank <= rd_bank; bst_slot <= rd_slot;
            bst_ptr <= a_ptr; bst_life <= a_life;
          end
          cnt <= cnt + CW'(1);
          if (cnt == LASTC) state <= S_ELDONE;
        end
        S_ELDONE: begin
          rsp_valid <= 1'b1; rsp_found <= bst_have;
          rsp_ptr <= bst_have ? bst_ptr : '0;
          rsp_prio <= bst_have ? bst_bank : '0;
          state <= S_IDLE;
        end
        S_INS: begin
          if (!a_vld || rd_slot == SW'(SLOTS - 1)) begin
            ins_done <= 1'b1; ins_err <= a_vld; state <= S_IDLE;
          end
          cnt <= cnt + CW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sem_grant |-> state == S_IDLE);
  // R6
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_found) &&
                                   $stable(rsp_ptr) && $stable(rsp_prio)));
  // R11
  tick_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> tick_pend);
  // R2
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_done |-> $past(state == S_INS));
endmodule

// File: rtl/frame_sched.sv
module frame_sched #(
  parameter int NUM_PRIO    = 4,
  parameter int SLOTS       = 64,
  parameter int PTR_W       = 32,
  parameter int LIFE_W      = 16,
  parameter int LIFE_RELOAD = 8,
  localparam int BW = $clog2(NUM_PRIO),
  localparam int SW = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              sem_req,
  output logic              sem_grant,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [PTR_W-1:0]  ins_ptr,
  input  logic [BW-1:0]     ins_prio,
  input  logic [LIFE_W-1:0] ins_life,
  output logic              ins_done,
  output logic              ins_err,
  input  logic              el_valid,
  output logic              el_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_found,
  output logic [PTR_W-1:0]  rsp_ptr,
  output logic [BW-1:0]     rsp_prio
);
  logic [BW-1:0]     rd_bank, wa_bank, wb_bank;
  logic [SW-1:0]     rd_slot, wa_slot;
  logic              a_vld, n_vld, wa_en, wa_vld, wb_en;
  logic [PTR_W-1:0]  a_ptr, wa_ptr, wb_ptr;
  logic [LIFE_W-1:0] a_life, wa_life, wb_life;

  fs_table #(.NUM_PRIO(NUM_PRIO), .SLOTS(SLOTS), .PTR_W(PTR_W), .LIFE_W(LIFE_W)) u_tab (
    .clk, .rst_n, .rd_bank, .rd_slot, .a_vld, .a_ptr, .a_life, .n_vld,
    .wa_en, .wa_bank, .wa_slot, .wa_vld, .wa_ptr, .wa_life,
    .wb_en, .wb_bank, .wb_ptr, .wb_life
  );

  fs_ctrl #(.NUM_PRIO(NUM_PRIO), .SLOTS(SLOTS), .PTR_W(PTR_W), .LIFE_W(LIFE_W),
            .LIFE_RELOAD(LIFE_RELOAD)) u_ctrl (
    .clk, .rst_n, .tick, .sem_req, .sem_grant,
    .ins_valid, .ins_ready, .ins_ptr, .ins_prio, .ins_life, .ins_done, .ins_err,
    .el_valid, .el_ready, .rsp_valid, .rsp_ready, .rsp_found, .rsp_ptr, .rsp_prio,
    .rd_bank, .rd_slot, .a_vld, .a_ptr, .a_life, .n_vld,
    .wa_en, .wa_bank, .wa_slot, .wa_vld, .wa_ptr, .wa_life,
    .wb_en, .wb_bank, .wb_ptr, .wb_life
  );
endmodule

// File: tb/tb_frame_sched.sv
module tb_frame_sched;
  localparam int NP = 4, NS = 4, PW = 32, LW = 16, RL = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, sem_req = 1'b0;
  logic ins_valid = 1'b0, el_valid = 1'b0, rsp_ready = 1'b0;
  logic [PW-1:0] ins_ptr = '0;
  logic [1:0]    ins_prio = '0;
  logic [LW-1:0] ins_life = '0;
  logic sem_grant, ins_ready, ins_done, ins_err, el_ready, rsp_valid, rsp_found;
  logic [PW-1:0] rsp_ptr;
  logic [1:0]    rsp_prio;

  always #5 clk = ~clk;

  frame_sched #(.NUM_PRIO(NP), .SLOTS(NS), .PTR_W(PW), .LIFE_W(LW), .LIFE_RELOAD(RL)) dut (
    .clk, .rst_n, .tick, .sem_req, .sem_grant, .ins_valid, .ins_ready, .ins_ptr,
    .ins_prio, .ins_life, .ins_done, .ins_err, .el_valid, .el_ready, .rsp_valid,
    .rsp_ready, .rsp_found, .rsp_ptr, .rsp_prio
  );

  // Reference tables
  bit mv[NP][NS];
  int mp[NP][NS];
  int ml[NP][NS];
  int checks = 0, fails = 0;
  bit ended = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic m_age();
    for (int b = NP - 1; b >= 0; b--)
      for (int s = 0; s < NS; s++)
        if (mv[b][s]) begin
          int d = (ml[b][s] > 0) ? ml[b][s] - 1 : 0;
          if (d == 0 && b < NP - 1 && !mv[b+1][s]) begin
            mv[b+1][s] = 1; mp[b+1][s] = mp[b][s]; ml[b+1][s] = RL; mv[b][s] = 0;
          end else ml[b][s] = d;
        end
  endtask

  task automatic m_elect(output bit f, output int p, output int pr);
    int bb = -1, bs = 0;
    for (int b = NP - 1; b >= 0; b--)
      for (int s = 0; s < NS; s++)
        if (mv[b][s] && (bb < 0 || (b == bb && ml[b][s] < ml[bb][bs]))) begin
          bb = b; bs = s;
        end
    f = (bb >= 0); p = 0; pr = 0;
    if (f) begin p = mp[bb][bs]; pr = bb; mv[bb][bs] = 0; end
  endtask

  task automatic wait_hi(ref logic sig, input string tag);
    int n = 0;
    while (!sig && n < 400) begin @(negedge clk); n++; end
    if (n >= 400) chk(tag, "timeout", 0, 1);
  endtask

  task automatic do_insert(input int p, input int pr, input int l, input string tag);
    bit err = 1;
    for (int s = 0; s < NS; s++)
      if (err && !mv[pr][s]) begin err = 0; mv[pr][s] = 1; mp[pr][s] = p; ml[pr][s] = l; end
    @(negedge clk);
    ins_valid = 1; ins_ptr = PW'(p); ins_prio = 2'(pr); ins_life = LW'(l);
    #1;
    while (!ins_ready) begin @(negedge clk); #1; end
    @(negedge clk); ins_valid = 0;
    wait_hi(ins_done, tag);
    chk(tag, "ins_err", ins_err, err);
  endtask

  task automatic take_rsp(input string tag, input int hold);
    bit f; int p, pr;
    m_elect(f, p, pr);
    wait_hi(rsp_valid, tag);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R6", "held valid", rsp_valid, 1);
      chk("R6", "held el_ready", el_ready, 0);
    end
    chk(tag, "found", rsp_found, f);
    chk(tag, "ptr", rsp_ptr, f ? p : 0);
    chk(tag, "prio", rsp_prio, f ? pr : 0);
    rsp_ready = 1;
    @(negedge clk); rsp_ready = 0;
    chk("R6", "cleared", rsp_valid, 0);
  endtask

  task automatic send_elect();
    @(negedge clk); el_valid = 1; #1;
    while (!el_ready) begin @(negedge clk); #1; end
    @(negedge clk); el_valid = 0;
  endtask

  task automatic do_elect(input string tag, input int hold = 0);
    send_elect();
    take_rsp(tag, hold);
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1; @(negedge clk); tick = 0;
    m_age();
    repeat (NP * NS + 4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "sem_grant", sem_grant, 0);
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "ins_ready", ins_ready, 1);
    chk("R1", "el_ready", el_ready, 1);

    do_elect("R5");

    // R2 / R4: priority, lifetime, slot order; R6 back-pressure on first
    do_insert(32'h11, 1, 5, "R2");
    do_insert(32'h22, 2, 9, "R2");
    do_insert(32'h33, 2, 3, "R2");
    do_insert(32'h44, 2, 3, "R2");
    do_elect("R4", 5);
    do_elect("R4");
    do_elect("R4");
    do_elect("R4");

    // R3: full table rejects and stays unchanged
    for (int i = 0; i < NS; i++) do_insert(32'hA0 + i, 0, 20, "R2");
    do_insert(32'hA4, 0, 1, "R3");
    for (int i = 0; i < NS; i++) do_elect("R3");
    do_elect("R5");

    // R7 / R8: ageing, blocked and free promotion
    do_insert(32'h50, 1, 3, "R2");
    do_insert(32'h51, 1, 2, "R2");
    do_tick();
    do_elect("R7");
    do_insert(32'h60, 0, 1, "R2");
    do_insert(32'h61, 0, 1, "R2");
    do_tick();
    do_elect("R8");
    do_elect("R8");
    do_elect("R8");
    do_elect("R5");

    // R9: top table holds expired entry at zero
    do_insert(32'h71, 3, 2, "R2");
    do_insert(32'h70, 3, 1, "R2");
    do_tick();
    do_tick();
    do_elect("R9");
    do_elect("R9");

    // R11: tick during an elect scan runs afterwards
    do_insert(32'h80, 2, 5, "R2");
    do_insert(32'h81, 2, 6, "R2");
    send_elect();
    tick = 1; @(negedge clk); tick = 0;
    take_rsp("R11", 0);
    m_age();
    repeat (NP * NS + 4) @(negedge clk);
    do_insert(32'h82, 2, 6, "R2");
    do_elect("R11");
    do_elect("R11");

    // R10 / R11: semaphore blocks work; latched tick precedes pending elect
    do_insert(32'h90, 0, 1, "R2");
    @(negedge clk); sem_req = 1;
    repeat (3) @(negedge clk);
    chk("R10", "sem_grant", sem_grant, 1);
    chk("R10", "ins_ready", ins_ready, 0);
    chk("R10", "el_ready", el_ready, 0);
    tick = 1; @(negedge clk); tick = 0;
    el_valid = 1;
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rsp_valid || ins_done || !sem_grant) bad++;
    end
    chk("R10", "activity while granted", bad, 0);
    m_age();
    sem_req = 0;
    #1;
    while (!el_ready) begin @(negedge clk); #1; end
    @(negedge clk); el_valid = 0;
    take_rsp("R11", 0);
    chk("R10", "sem_grant released", sem_grant, 0);
    do_elect("R5");

    finish_run();
  end
endmodule